// File: doc/BRIEF.md
# Two-Stage Pixel Byte Shifter

A memory-mapped helper for bitmap video that moves 8-bit graphics bytes by 0 to 7 pixels across byte boundaries. The CPU writes bytes of pixels into a two-deep data pipe and writes a small offset register. It then reads back one byte cut from the 16-bit window made of the newest byte and the byte written before it. The bits pushed out of one byte land in the low bits of the next result, so an object can be drawn at any pixel position as a stream of byte writes and reads.

Writing the same byte twice fills both stages with one value, and the result is then that byte rotated left by the offset. A test routine can use this to check the shifter on its own. The block contains only the stage registers, the offset register, the window slice and the bus decode. The result byte is registered and becomes valid on the clock edge that captures the read.

Top module: `pxs_shifter`

## Requirements
- R1: A write at address 1 stores `bus_wdata[2:0]` as the shift amount s. Bits 7:3 of the written byte are ignored.
- R2: A write at address 0 moves the byte held in the newest stage into the older stage and puts `bus_wdata` into the newest stage.
- R3: The result byte is bits [15-s : 8-s] of the 16-bit window {newest, older}, which equals the upper byte of ({newest, older} << s).
- R4: After the same byte has been written twice at address 0, the result equals that byte rotated left by s, with bit 7 wrapping into bit 0.
- R5: With s = 0 the result equals the newest byte unchanged.
- R6: A write at address 1, 2 or 3 leaves both data stages unchanged. A write at address 2 or 3 also leaves the shift amount unchanged.
- R7: A read at address 0 loads the result into `bus_rdata` at the next rising clock edge. A read at address 1, 2 or 3 loads zero. A read changes no stored state.
- R8: `bus_rdata` keeps its value in every cycle that has no read strobe.
- R9: When a write and a read are strobed in the same cycle, the read returns the result computed from the state before that write.
- R10: A synchronous active-high reset clears both data stages, the shift amount and `bus_rdata` to zero.
- R11: While `bus_sel` is low, write and read strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Selects the block for the current bus cycle |
| bus_addr | input | 2 | Register address: 0 = data write and result read, 1 = shift amount write, 2 and 3 are unused |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
The embedded properties check the following on every clock cycle:
- Each data write moves the stages correctly, and any other cycle leaves them untouched.
- The shift amount holds between writes to it.
- Reset clears the state.
- A shift amount of zero passes the newest byte through.
- Equal stages give a rotation.
- The read data holds when there is no read, and the unused addresses read as zero.

Two behaviours need the bench's sequences to show them:
- The exact slice for mixed byte pairs at every shift amount.
- Which state a read sees when a write is strobed in the same cycle.

The bench checks both against its own model, under seeded random traffic and under directed cases.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

  localparam int PXS_ADDR_W = 2;

  typedef enum logic [PXS_ADDR_W-1:0] {
    OFS_DATA = 2'd0,
    OFS_AMT  = 2'd1,
    OFS_RSV2 = 2'd2,
    OFS_RSV3 = 2'd3
  } pxs_ofs_e;

  typedef struct packed {
    logic data_wr;
    logic amt_wr;
    logic res_rd;
    logic zero_rd;
  } pxs_strobe_t;

endpackage

// File: rtl/pxs_decode.sv
module pxs_decode
  import pxs_pkg::*;
(
  input  logic                  sel,
  input  logic [PXS_ADDR_W-1:0] addr,
  input  logic                  wr,
  input  logic                  rd,
  output pxs_strobe_t           strb
);

  logic wr_hit;
  logic rd_hit;
  logic at_data;

  assign wr_hit  = sel & wr;
  assign rd_hit  = sel & rd;
  assign at_data = (addr == OFS_DATA);

  always_comb begin
    strb.data_wr = wr_hit & at_data;
    strb.amt_wr  = wr_hit & (addr == OFS_AMT);
    strb.res_rd  = rd_hit & at_data;
    strb.zero_rd = rd_hit & ~at_data;
  end

endmodule

// File: rtl/pxs_window.sv
module pxs_window #(
  parameter int DATA_W = 8,
  parameter int SHW    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_wr,
  input  logic              amt_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] newest,
  output logic [DATA_W-1:0] older,
  output logic [SHW-1:0]    amt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      newest <= '0;
      older  <= '0;
      amt    <= '0;
    end else begin
      if (data_wr) begin
        older  <= newest;
        newest <= wdata;
      end
      if (amt_wr) begin
        amt <= wdata[SHW-1:0];
      end
    end
  end

  // R2: pipe advance on a data write
  a_r2_stage_move: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> (newest == $past(wdata) && older == $past(newest)));

  // R6: stages untouched unless a data write occurs
  a_r6_stage_keep: assert property (@(posedge clk) disable iff (rst)
    !data_wr |=> ($stable(newest) && $stable(older)));

  // R1: amount changes only through its own write
  a_r1_amt_keep: assert property (@(posedge clk) disable iff (rst)
    !amt_wr |=> $stable(amt));

  // R10: reset clears all state
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (newest == '0 && older == '0 && amt == '0));

endmodule

// File: rtl/pxs_slice.sv
module pxs_slice #(
  parameter int DATA_W = 8,
  parameter int SHW    = 3
) (
  input  logic [DATA_W-1:0] newest,
  input  logic [DATA_W-1:0] older,
  input  logic [SHW-1:0]    amt,
  output logic [DATA_W-1:0] result
);

  localparam int WIN_W = 2 * DATA_W;

  logic [WIN_W-1:0]  win;
  logic [DATA_W-1:0] cand [DATA_W];

  assign win = {newest, older};

  for (genvar g = 0; g < DATA_W; g++) begin : g_tap
    assign cand[g] = win[WIN_W-1-g -: DATA_W];
  end

  assign result = cand[amt];

  function automatic logic [DATA_W-1:0] rotl(input logic [DATA_W-1:0] v,
                                             input logic [SHW-1:0] n);
    logic [DATA_W-1:0] r;
    r = v;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(n)) r = {r[DATA_W-2:0], r[DATA_W-1]};
    end
    return rotl_done(r);
  endfunction

  function automatic logic [DATA_W-1:0] rotl_done(input logic [DATA_W-1:0] v);
    return v;
  endfunction

  always_comb begin
    if (amt == '0) begin
      // R5: zero amount passes newest byte
      a_r5_zero_amt: assert (result == newest)
        else $error("zero amount did not pass newest byte");
    end
    if (newest == older) begin
      // R4: equal stages give a rotation
      a_r4_rotate: assert (result == rotl(newest, amt))
        else $error("equal stages did not rotate");
    end
  end

endmodule

// File: rtl/pxs_shifter.sv
module pxs_shifter
  import pxs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_sel,
  input  logic [PXS_ADDR_W-1:0] bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata
);

  localparam int SHW = $clog2(DATA_W);

  pxs_strobe_t       strb;
  logic [DATA_W-1:0] newest;
  logic [DATA_W-1:0] older;
  logic [SHW-1:0]    amt;
  logic [DATA_W-1:0] result;

  pxs_decode u_decode (
    .sel  (bus_sel),
    .addr (bus_addr),
    .wr   (bus_wr),
    .rd   (bus_rd),
    .strb (strb)
  );

  pxs_window #(.DATA_W(DATA_W), .SHW(SHW)) u_window (
    .clk     (clk),
    .rst     (rst),
    .data_wr (strb.data_wr),
    .amt_wr  (strb.amt_wr),
    .wdata   (bus_wdata),
    .newest  (newest),
    .older   (older),
    .amt     (amt)
  );

  pxs_slice #(.DATA_W(DATA_W), .SHW(SHW)) u_slice (
    .newest (newest),
    .older  (older),
    .amt    (amt),
    .result (result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (strb.res_rd) begin
      bus_rdata <= result;
    end else if (strb.zero_rd) begin
      bus_rdata <= '0;
    end
  end

  // R8: read data holds without a read strobe
  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && bus_rd) |=> $stable(bus_rdata));

  // R7: reads at non-result addresses return zero
  a_r7_other_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_rd && bus_addr != OFS_DATA) |=> (bus_rdata == '0));

  // R11: deselected cycles leave read data alone
  a_r11_desel_idle: assert property (@(posedge clk) disable iff (rst)
    !bus_sel |=> $stable(bus_rdata));

endmodule

// File: tb/pxs_shifter_test.sv
module pxs_shifter_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m_new = 8'd0;
  logic [7:0] m_old = 8'd0;
  logic [2:0] m_amt = 3'd0;
  logic [7:0] m_rd  = 8'd0;

  always #10 clk = ~clk;

  pxs_shifter uut (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  function automatic logic [7:0] exp_res(input logic [7:0] n, input logic [7:0] o,
                                         input logic [2:0] s);
    logic [15:0] w;
    w = {n, o} << s;
    return w[15:8];
  endfunction

  function automatic logic [7:0] rot8(input logic [7:0] v, input int s);
    logic [15:0] t;
    t = {v, v} << s;
    return t[15:8];
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // One bus cycle: drive at negedge, edge captures, sample at next negedge.
  task automatic op(input logic s, input logic [1:0] a, input logic w, input logic r,
                    input logic [7:0] d);
    @(negedge clk);
    bus_sel = s; bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
    if (s && r) m_rd = (a == 2'd0) ? exp_res(m_new, m_old, m_amt) : 8'd0;
    if (s && w && a == 2'd0) begin m_old = m_new; m_new = d; end
    if (s && w && a == 2'd1) m_amt = d[2:0];
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    op(1'b1, a, 1'b1, 1'b0, d);
  endtask

  task automatic rd(input logic [1:0] a);
    op(1'b1, a, 1'b0, 1'b1, 8'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_new = 8'd0; m_old = 8'd0; m_amt = 3'd0; m_rd = 8'd0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd20240611));
    do_reset();

    // R10: reset state
    check("R10 rdata after reset", bus_rdata, 8'h00);
    rd(2'd0);
    check("R10 result after reset", bus_rdata, 8'h00);

    // R4 / R5: same byte twice, every amount
    foreach (bus_rdata[k]) begin
      logic [7:0] v;
      v = (k == 0) ? 8'hA5 : ((k == 1) ? 8'h81 : 8'($urandom));
      wr(2'd0, v);
      wr(2'd0, v);
      for (int s = 0; s < 8; s++) begin
        wr(2'd1, 8'(s));
        rd(2'd0);
        check((s == 0) ? "R5 zero amount" : "R4 rotate", bus_rdata, rot8(v, s));
      end
    end

    // R2 / R3: distinct bytes carry across boundary
    wr(2'd0, 8'hF0);
    wr(2'd0, 8'h0F);
    wr(2'd1, 8'd3);
    rd(2'd0);
    check("R3 carry slice", bus_rdata, 8'h7F);
    wr(2'd0, 8'h00);
    rd(2'd0);
    check("R2 stage move", bus_rdata, 8'h00);

    // R1: upper amount bits ignored (0xF9 -> s=1)
    wr(2'd0, 8'h80);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'hF9);
    rd(2'd0);
    check("R1 amount low bits", bus_rdata, 8'h03);

    // R6: amount and unused writes keep stages; unused writes keep amount
    wr(2'd1, 8'd0);
    wr(2'd2, 8'hEE);
    wr(2'd3, 8'hDD);
    rd(2'd0);
    check("R6 unused writes", bus_rdata, 8'h01);
    wr(2'd1, 8'd7);
    wr(2'd3, 8'd2);
    rd(2'd0);
    check("R6 amount write keeps data", bus_rdata, 8'hC0);

    // R7: other addresses read zero, reads have no side effect
    rd(2'd1);
    check("R7 other read zero", bus_rdata, 8'h00);
    rd(2'd0);
    rd(2'd0);
    check("R7 read no side effect", bus_rdata, 8'hC0);

    // R8: hold without reads
    held = bus_rdata;
    wr(2'd0, 8'h55);
    op(1'b0, 2'd0, 1'b0, 1'b0, 8'h00);
    check("R8 hold", bus_rdata, held);

    // R9: simultaneous write and read sees old state
    wr(2'd1, 8'd0);
    op(1'b1, 2'd0, 1'b1, 1'b1, 8'h3C);
    check("R9 read before write", bus_rdata, 8'h55);
    rd(2'd0);
    check("R9 write took effect", bus_rdata, 8'h3C);

    // R11: deselected strobes ignored
    op(1'b0, 2'd0, 1'b1, 1'b1, 8'h99);
    op(1'b0, 2'd1, 1'b1, 1'b0, 8'h04);
    check("R11 desel read", bus_rdata, 8'h3C);
    rd(2'd0);
    check("R11 desel write", bus_rdata, 8'h3C);

    // Seeded random traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic s, w, r;
      logic [1:0] a;
      s = ($urandom % 8) != 0;
      a = (($urandom % 3) == 0) ? 2'($urandom) : 2'($urandom % 2);
      w = $urandom;
      r = $urandom;
      op(s, a, w, r, 8'($urandom));
      check("R3 random model", bus_rdata, m_rd);
    end

    // R10: reset in mid-run
    wr(2'd0, 8'hAB);
    wr(2'd1, 8'd5);
    rd(2'd0);
    do_reset();
    check("R10 mid-run rdata", bus_rdata, 8'h00);
    wr(2'd0, 8'h00);
    rd(2'd0);
    check("R10 mid-run stages", bus_rdata, 8'h00);

    finish_run();
  end

endmodule